// File: doc/BRIEF.md
# Two-Queue Conversion Command Scheduler

This block feeds one shared analog-to-digital converter from two independent command queues. Each queue holds a short list of conversion command words. Each word carries a channel number, a pause marker and an end marker. The block picks which queue owns the converter, issues a start pulse with the selected channel, and takes back a done pulse. It then moves the owning queue on to its next word.

Queue 1 has the higher priority. A queue 1 trigger that arrives while queue 2 is converting aborts that conversion. The aborted word produces no result and queue 2 runs it again later. A queue can halt at a word marked for pause and continue from the following word on its next trigger. A queue in continuous mode restarts itself after its last word. Sticky status flags report pause, end-of-scan and trigger overrun for each queue.

Top module: `conv_q_sched`

## Requirements
- R1: After reset no start or abort is issued, the queues are idle, and all pause, end and overrun flags (bit 0 = queue 1, bit 1 = queue 2) read 0.
- R2: A trigger sampled on an idle queue makes that queue pending. The cycle after that edge, if the converter is free, `adc_start_o` pulses with the channel of word 0.
- R3: A done pulse completes the owner's word: `res_valid_o` is high in that cycle with `res_queue_o` (0 = queue 1, 1 = queue 2). A queue that has not ended issues its next start in the following cycle at the earliest. Only one queue ever converts at a time.
- R4: Completing a word whose pause bit (bit CH_W of the word) is set sets that queue's pause flag and halts it. Its next trigger resumes it at the following word.
- R5: Completing a word whose end bit (bit CH_W+1) is set, or the last slot, sets the end flag and idles the queue. Its next trigger restarts it at word 0. The end bit takes precedence over the pause bit.
- R6: When both queues are pending and the converter is free, queue 1 is started.
- R7: When queue 1 is pending while queue 2 converts and no done arrives, `adc_abort_o` and `adc_start_o` pulse together with the queue 1 channel. The aborted queue 2 word gives no result and is executed again later.
- R8: If done arrives in the cycle in which a preemption would occur, queue 2's word completes with a result and no abort is issued. Queue 1 starts in the next cycle.
- R9: A trigger to a queue that is pending or converting is ignored (its scan position is unchanged) and sets that queue's overrun flag.
- R10: In continuous mode a queue that ends re-triggers itself. Its word 0 starts two cycles after the final done, with no external trigger.
- R11: Queue 1 is triggered by its external or software input. Queue 2 is triggered by its external, software or timer input.
- R12: A queue's three flags are cleared when that queue accepts a trigger.
- R13: A done pulse while no queue converts is ignored: no result, and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q1_ext_trig_i | input | 1 | Queue 1 external trigger |
| q1_sw_trig_i | input | 1 | Queue 1 software single-scan trigger |
| q2_ext_trig_i | input | 1 | Queue 2 external trigger |
| q2_sw_trig_i | input | 1 | Queue 2 software single-scan trigger |
| q2_tmr_trig_i | input | 1 | Queue 2 timer period expiry |
| q1_cont_i | input | 1 | Queue 1 continuous mode |
| q2_cont_i | input | 1 | Queue 2 continuous mode |
| q1_ccw_i | input | N_CCW*(CH_W+2) | Queue 1 words, word k at bits k*(CH_W+2) upward |
| q2_ccw_i | input | N_CCW*(CH_W+2) | Queue 2 words, same layout |
| adc_done_i | input | 1 | Converter finished current conversion |
| adc_start_o | output | 1 | Start a conversion |
| adc_abort_o | output | 1 | Discard the running conversion |
| adc_chan_o | output | CH_W | Channel for the start |
| res_valid_o | output | 1 | A word completed with a result |
| res_queue_o | output | 1 | Queue of the completed word |
| res_idx_o | output | $clog2(N_CCW) | Slot of the completed word |
| pause_flag_o | output | 2 | Pause reached, per queue |
| end_flag_o | output | 2 | End of scan reached, per queue |
| ovr_flag_o | output | 2 | Trigger overrun, per queue |

## Verification
The sharpest coincidence is a converter done pulse landing in the same cycle in which a fresh queue 1 trigger would preempt queue 2. The bench arranges this by triggering queue 1 while queue 2 converts and raising done in the first cycle queue 1 is pending. It then expects a queue 2 result with no abort, and a queue 1 start one cycle later. A second coincidence is a trigger arriving in the cycle a queue completes a word. This is judged by the resumed channel and by the overrun flag.

// File: rtl/conv_q_sched_pkg.sv
package conv_q_sched_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_PEND  = 2'd1,
    QS_CONV  = 2'd2,
    QS_PAUSE = 2'd3
  } qstate_e;

  localparam int unsigned NUM_Q = 2;
  localparam int unsigned Q_HI  = 0;
  localparam int unsigned Q_LO  = 1;
endpackage

// File: rtl/qs_queue_ctrl.sv
module qs_queue_ctrl
  import conv_q_sched_pkg::*;
#(
  parameter int unsigned N_CCW = 4,
  parameter int unsigned CH_W  = 5,
  localparam int unsigned CCW_W = CH_W + 2,
  localparam int unsigned IDX_W = (N_CCW > 1) ? $clog2(N_CCW) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trig_i,
  input  logic                   cont_i,
  input  logic [N_CCW*CCW_W-1:0] ccw_tbl_i,
  input  logic                   grant_i,
  input  logic                   preempt_i,
  input  logic                   done_i,
  output logic                   pend_o,
  output logic                   conv_o,
  output logic [CH_W-1:0]        chan_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   pause_o,
  output logic                   end_o,
  output logic                   ovr_o
);
  qstate_e          state_q;
  logic [IDX_W-1:0] idx_q;
  logic             loop_trig_q;
  logic [CCW_W-1:0] cur_ccw;
  logic             cur_pause, cur_end, trig_any;

  assign cur_ccw   = ccw_tbl_i[idx_q*CCW_W +: CCW_W];
  assign cur_pause = cur_ccw[CH_W];
  // end bit or last slot terminates the scan; wins over pause
  assign cur_end   = cur_ccw[CH_W+1] | (idx_q == IDX_W'(N_CCW - 1));
  assign trig_any  = trig_i | loop_trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= QS_IDLE;
      idx_q       <= '0;
      loop_trig_q <= 1'b0;
      pause_o     <= 1'b0;
      end_o       <= 1'b0;
      ovr_o       <= 1'b0;
    end else begin
      loop_trig_q <= 1'b0;
      unique case (state_q)
        QS_IDLE: if (trig_any) begin
          state_q <= QS_PEND;
          idx_q   <= '0;
          pause_o <= 1'b0;
          end_o   <= 1'b0;
          ovr_o   <= 1'b0;
        end
        QS_PAUSE: if (trig_any) begin
          state_q <= QS_PEND;
          pause_o <= 1'b0;
          end_o   <= 1'b0;
          ovr_o   <= 1'b0;
        end
        QS_PEND: begin
          if (trig_any) ovr_o <= 1'b1;
          if (grant_i) state_q <= QS_CONV;
        end
        QS_CONV: begin
          if (trig_any) ovr_o <= 1'b1;
          if (preempt_i) begin
            state_q <= QS_PEND;  // same slot is re-run
          end else if (done_i) begin
            if (cur_end) begin
              state_q     <= QS_IDLE;
              end_o       <= 1'b1;
              loop_trig_q <= cont_i;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (cur_pause) begin
                state_q <= QS_PAUSE;
                pause_o <= 1'b1;
              end else begin
                state_q <= QS_PEND;
              end
            end
          end
        end
        default: state_q <= QS_IDLE;
      endcase
    end
  end

  assign pend_o = (state_q == QS_PEND);
  assign conv_o = (state_q == QS_CONV);
  assign chan_o = cur_ccw[CH_W-1:0];
  assign idx_o  = idx_q;
endmodule

// File: rtl/qs_arbiter.sv
module qs_arbiter
  import conv_q_sched_pkg::*;
#(
  parameter int unsigned CH_W = 5
) (
  input  logic [NUM_Q-1:0] pend_i,
  input  logic [NUM_Q-1:0] conv_i,
  input  logic             done_i,
  input  logic [CH_W-1:0]  chan_hi_i,
  input  logic [CH_W-1:0]  chan_lo_i,
  output logic [NUM_Q-1:0] grant_o,
  output logic             preempt_o,
  output logic [NUM_Q-1:0] done_o,
  output logic             start_o,
  output logic             abort_o,
  output logic [CH_W-1:0]  chan_o
);
  logic busy;

  assign busy      = |conv_i;
  // a done in the same cycle lets the low queue finish instead
  assign preempt_o = conv_i[Q_LO] & pend_i[Q_HI] & ~done_i;

  always_comb begin
    grant_o        = '0;
    grant_o[Q_HI]  = pend_i[Q_HI] & (~busy | preempt_o);
    grant_o[Q_LO]  = pend_i[Q_LO] & ~pend_i[Q_HI] & ~busy;
  end

  assign done_o  = {NUM_Q{done_i}} & conv_i;
  assign start_o = |grant_o;
  assign abort_o = preempt_o;
  assign chan_o  = grant_o[Q_HI] ? chan_hi_i : chan_lo_i;
endmodule

// File: rtl/conv_q_sched.sv
module conv_q_sched
  import conv_q_sched_pkg::*;
#(
  parameter int unsigned N_CCW = 4,
  parameter int unsigned CH_W  = 5,
  localparam int unsigned CCW_W = CH_W + 2,
  localparam int unsigned TBL_W = N_CCW * CCW_W,
  localparam int unsigned IDX_W = (N_CCW > 1) ? $clog2(N_CCW) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q1_ext_trig_i,
  input  logic             q1_sw_trig_i,
  input  logic             q2_ext_trig_i,
  input  logic             q2_sw_trig_i,
  input  logic             q2_tmr_trig_i,
  input  logic             q1_cont_i,
  input  logic             q2_cont_i,
  input  logic [TBL_W-1:0] q1_ccw_i,
  input  logic [TBL_W-1:0] q2_ccw_i,
  input  logic             adc_done_i,
  output logic             adc_start_o,
  output logic             adc_abort_o,
  output logic [CH_W-1:0]  adc_chan_o,
  output logic             res_valid_o,
  output logic             res_queue_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [1:0]       pause_flag_o,
  output logic [1:0]       end_flag_o,
  output logic [1:0]       ovr_flag_o
);
  logic [NUM_Q-1:0] q_trig, q_cont, q_pend, q_conv, q_grant, q_pre, q_done;
  logic [TBL_W-1:0] q_tbl  [NUM_Q];
  logic [CH_W-1:0]  q_chan [NUM_Q];
  logic [IDX_W-1:0] q_idx  [NUM_Q];
  logic             preempt;

  assign q_trig[Q_HI] = q1_ext_trig_i | q1_sw_trig_i;
  assign q_trig[Q_LO] = q2_ext_trig_i | q2_sw_trig_i | q2_tmr_trig_i;
  assign q_cont       = {q2_cont_i, q1_cont_i};
  assign q_tbl[Q_HI]  = q1_ccw_i;
  assign q_tbl[Q_LO]  = q2_ccw_i;

  always_comb begin
    q_pre       = '0;
    q_pre[Q_LO] = preempt;
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    qs_queue_ctrl #(.N_CCW(N_CCW), .CH_W(CH_W)) u_q (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (q_trig[g]),
      .cont_i    (q_cont[g]),
      .ccw_tbl_i (q_tbl[g]),
      .grant_i   (q_grant[g]),
      .preempt_i (q_pre[g]),
      .done_i    (q_done[g]),
      .pend_o    (q_pend[g]),
      .conv_o    (q_conv[g]),
      .chan_o    (q_chan[g]),
      .idx_o     (q_idx[g]),
      .pause_o   (pause_flag_o[g]),
      .end_o     (end_flag_o[g]),
      .ovr_o     (ovr_flag_o[g])
    );
  end

  qs_arbiter #(.CH_W(CH_W)) u_arb (
    .pend_i    (q_pend),
    .conv_i    (q_conv),
    .done_i    (adc_done_i),
    .chan_hi_i (q_chan[Q_HI]),
    .chan_lo_i (q_chan[Q_LO]),
    .grant_o   (q_grant),
    .preempt_o (preempt),
    .done_o    (q_done),
    .start_o   (adc_start_o),
    .abort_o   (adc_abort_o),
    .chan_o    (adc_chan_o)
  );

  assign res_valid_o = |q_done;
  assign res_queue_o = q_done[Q_LO];
  assign res_idx_o   = q_done[Q_LO] ? q_idx[Q_LO] : q_idx[Q_HI];
endmodule

// File: rtl/conv_q_sched_chk.sv
module conv_q_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] conv_i,
  input logic [1:0] trig_i,
  input logic       adc_start_o,
  input logic       adc_abort_o,
  input logic       adc_done_i,
  input logic       res_valid_o,
  input logic [1:0] pause_flag_o,
  input logic [1:0] end_flag_o,
  input logic [1:0] ovr_flag_o
);
  a_r3_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_i[0] && conv_i[1]));

  a_r3_start_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && (|conv_i)) |-> adc_abort_o);

  a_r7_abort_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_abort_o |-> (adc_start_o && conv_i[1]));

  a_r7_abort_returns_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_abort_o |=> (conv_i[0] && !conv_i[1]));

  a_r8_done_beats_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_done_i |-> !adc_abort_o);

  for (genvar g = 0; g < 2; g++) begin : g_f
    a_r9_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovr_flag_o[g]) |-> $past(trig_i[g]));
    a_r4_pause_after_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pause_flag_o[g]) |-> $past(res_valid_o));
    a_r5_end_after_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(end_flag_o[g]) |-> $past(res_valid_o));
  end
endmodule

bind conv_q_sched conv_q_sched_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_i       (q_conv),
  .trig_i       (q_trig),
  .adc_start_o  (adc_start_o),
  .adc_abort_o  (adc_abort_o),
  .adc_done_i   (adc_done_i),
  .res_valid_o  (res_valid_o),
  .pause_flag_o (pause_flag_o),
  .end_flag_o   (end_flag_o),
  .ovr_flag_o   (ovr_flag_o)
);

// File: tb/conv_q_sched_bench.sv
`timescale 1ns/1ps
module conv_q_sched_bench;
  localparam int N_CCW = 4;
  localparam int CH_W  = 5;
  localparam int TBL_W = N_CCW * (CH_W + 2);

  function automatic logic [6:0] mk(input logic e, input logic p, input logic [4:0] c);
    return {e, p, c};
  endfunction

  localparam logic [TBL_W-1:0] Q1_TBL = {mk(0,0,5'd4), mk(0,0,5'd3), mk(0,1,5'd2), mk(0,0,5'd1)};
  localparam logic [TBL_W-1:0] Q2_TBL = {mk(0,0,5'd20), mk(0,0,5'd19), mk(0,0,5'd18), mk(0,0,5'd17)};

  // {q1 ext, q2 tmr, done, exp start, exp abort, exp result valid, exp result queue, exp chan}
  localparam logic [11:0] VEC [20] = '{
    12'b0_1_0_0_0_0_0_00000,  // R2 q2 triggered
    12'b0_0_0_1_0_0_0_10001,  // q2 word0 starts
    12'b1_0_0_0_0_0_0_00000,  // q1 triggered while q2 converts
    12'b0_0_0_1_1_0_0_00001,  // R7 abort + q1 start
    12'b0_0_1_0_0_1_0_00000,
    12'b0_0_0_1_0_0_0_00010,  // R6 q1 before q2
    12'b0_0_1_0_0_1_0_00000,  // R4 q1 pauses
    12'b0_0_0_1_0_0_0_10001,  // R7 aborted q2 word re-run
    12'b0_0_1_0_0_1_1_00000,
    12'b0_0_0_1_0_0_0_10010,
    12'b1_0_1_0_0_1_1_00000,  // resume q1 with a q2 done
    12'b0_0_0_1_0_0_0_00011,
    12'b0_0_1_0_0_1_0_00000,
    12'b0_0_0_1_0_0_0_00100,
    12'b0_0_1_0_0_1_0_00000,  // R5 q1 ends
    12'b0_0_0_1_0_0_0_10011,
    12'b0_0_1_0_0_1_1_00000,
    12'b0_0_0_1_0_0_0_10100,
    12'b0_0_1_0_0_1_1_00000,
    12'b0_0_0_0_0_0_0_00000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q1e = 0, q1s = 0, q2e = 0, q2s = 0, q2m = 0, q1c = 0, q2c = 0, done = 0;
  logic [TBL_W-1:0] q1_tbl = Q1_TBL, q2_tbl = Q2_TBL;
  logic start, abort, rv, rq;
  logic [CH_W-1:0] chan;
  logic [1:0] rix, pf, ef, of;
  logic o_start, o_abort, o_rv, o_rq;
  logic [CH_W-1:0] o_chan;
  logic [1:0] o_pf, o_ef, o_of;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  conv_q_sched #(.N_CCW(N_CCW), .CH_W(CH_W)) u_conv_q_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .q1_ext_trig_i(q1e), .q1_sw_trig_i(q1s),
    .q2_ext_trig_i(q2e), .q2_sw_trig_i(q2s), .q2_tmr_trig_i(q2m),
    .q1_cont_i(q1c), .q2_cont_i(q2c),
    .q1_ccw_i(q1_tbl), .q2_ccw_i(q2_tbl),
    .adc_done_i(done),
    .adc_start_o(start), .adc_abort_o(abort), .adc_chan_o(chan),
    .res_valid_o(rv), .res_queue_o(rq), .res_idx_o(rix),
    .pause_flag_o(pf), .end_flag_o(ef), .ovr_flag_o(of)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, sample, cross posedge
  task automatic cyc(input logic a1e, input logic a1s, input logic a2e,
                     input logic a2s, input logic a2m, input logic ad);
    q1e = a1e; q1s = a1s; q2e = a2e; q2s = a2s; q2m = a2m; done = ad;
    #1;
    o_start = start; o_abort = abort; o_chan = chan; o_rv = rv; o_rq = rq;
    o_pf = pf; o_ef = ef; o_of = of;
    @(posedge clk);
    @(negedge clk);
    q1e = 0; q1s = 0; q2e = 0; q2s = 0; q2m = 0; done = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    cyc(0,0,0,0,0,0);
    chk(o_start == 0 && o_abort == 0, "R1 start/abort", {o_start, o_abort}, 0);
    chk({o_pf, o_ef, o_of} == 6'd0, "R1 flags", {o_pf, o_ef, o_of}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 20; i++) begin
      logic [11:0] v;
      v = VEC[i];
      cyc(v[11], 0, 0, 0, v[10], v[9]);
      chk(o_start == v[8], v[7] ? "R7 start" : "R3 start", o_start, v[8]);
      chk(o_abort == v[7], "R7 abort", o_abort, v[7]);
      chk(o_rv == v[6], "R3 result valid", o_rv, v[6]);
      if (v[6]) chk(o_rq == v[5], "R3 result queue", o_rq, v[5]);
      if (v[8]) chk(o_chan == v[4:0], "R2 channel", o_chan, v[4:0]);
      if (i == 7) chk(o_pf == 2'b01, "R4 pause flag", o_pf, 1);
    end
    cyc(0,0,0,0,0,0);
    chk(o_ef == 2'b11, "R5 end flags", o_ef, 3);
    chk(o_pf == 2'b00, "R12 pause cleared by resume", o_pf, 0);

    // R9 overrun
    do_reset();
    q1_tbl = Q1_TBL; q2_tbl = Q2_TBL;
    cyc(0,1,0,0,0,0);
    cyc(1,0,0,0,0,0);
    chk(o_start == 1 && o_chan == 1, "R9 first start", o_chan, 1);
    cyc(0,1,0,0,0,0);
    chk(o_of == 2'b01, "R9 ovr flag", o_of, 1);
    chk(o_start == 0, "R9 no restart", o_start, 0);
    cyc(0,0,0,0,0,1);
    cyc(0,0,0,0,0,0);
    chk(o_start == 1 && o_chan == 2, "R9 position kept", o_chan, 2);

    // R8 done in preemption cycle
    do_reset();
    cyc(0,0,0,0,1,0);
    cyc(0,0,0,0,0,0);
    chk(o_chan == 17 && o_start, "R11 timer source", o_chan, 17);
    cyc(1,0,0,0,0,0);
    cyc(0,0,0,0,0,1);
    chk(o_abort == 0, "R8 no abort", o_abort, 0);
    chk(o_rv == 1 && o_rq == 1, "R8 q2 result", {o_rv, o_rq}, 3);
    chk(o_start == 0, "R8 no start yet", o_start, 0);
    cyc(0,0,0,0,0,0);
    chk(o_start == 1 && o_abort == 0 && o_chan == 1, "R8 q1 starts next", o_chan, 1);

    // R10 continuous, R12 flag clear
    do_reset();
    q2c = 1;
    cyc(0,0,0,1,0,0);
    for (int k = 0; k < 4; k++) begin
      cyc(0,0,0,0,0,0);
      chk(o_start == 1 && o_chan == 17 + k, "R10 scan word", o_chan, 17 + k);
      cyc(0,0,0,0,0,1);
    end
    cyc(0,0,0,0,0,0);
    chk(o_start == 0 && o_ef[1] == 1, "R10 end then gap", {o_start, o_ef[1]}, 1);
    cyc(0,0,0,0,0,0);
    chk(o_start == 1 && o_chan == 17, "R10 self restart", o_chan, 17);
    chk(o_ef[1] == 0, "R12 end flag cleared", o_ef[1], 0);
    q2c = 0;

    // R5 early end bit
    do_reset();
    q2_tbl = Q2_TBL;
    q2_tbl[1*7 + 6] = 1'b1;
    cyc(0,0,1,0,0,0);
    cyc(0,0,0,0,0,0);
    cyc(0,0,0,0,0,1);
    cyc(0,0,0,0,0,0);
    chk(o_chan == 18 && o_start, "R5 second word", o_chan, 18);
    cyc(0,0,0,0,0,1);
    cyc(0,0,0,0,0,0);
    chk(o_start == 0 && o_ef[1] == 1, "R5 early end", {o_start, o_ef[1]}, 1);
    cyc(0,0,0,1,0,0);
    cyc(0,0,0,0,0,0);
    chk(o_start == 1 && o_chan == 17, "R5 restart at word 0", o_chan, 17);
    q2_tbl = Q2_TBL;

    // R13 stray done
    do_reset();
    cyc(0,0,0,0,0,1);
    chk(o_rv == 0, "R13 no result", o_rv, 0);
    cyc(0,0,0,0,0,0);
    chk({o_pf, o_ef, o_of} == 6'd0, "R13 flags unchanged", {o_pf, o_ef, o_of}, 0);
    cyc(0,1,0,0,0,0);
    cyc(0,0,0,0,0,0);
    chk(o_start == 1 && o_chan == 1, "R11 R13 sw trigger from word 0", o_chan, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule